// File: doc/BRIEF.md
# Voltage-Code Control and Status Register File

This block is the memory-mapped register file of an adaptive supply-voltage controller. A host reaches it through a 32-bit, single-cycle, non-bursting slave port with a 3-bit word address. Six words are decoded. Three are control words: the start and sensor-enable policy bits, the compute interval and step, and the device permission bit. One word is a read-only image of the voltage fuses, one word reads as zero, and one is a read-only status word that carries temperature and adaptive-code results.

The control fields leave the block as registered outputs for the sequencer and the temperature front end. The live results of those units come back in as inputs and appear in read-only fields. Some of those fields are forced to zero depending on the sensor-enable bit and the adaptive-active flag. The block also forms one registered adaptive-enable signal. That signal is the AND of four permissions, and they come from three different words.

Top module: `vidreg_csr`

## Requirements
- R1: After a synchronous reset the outputs are: `op_start` = parameter START_RST (default 0), `sense_en` = 1, `dyn_adapt_en` = 0, `comp_delay` = 0, `vid_step` = 2, `dev_adapt_ok` = 0, `adapt_en` = 0 and `bus_rdata` = 0.
- R2: When `bus_read` is high at a rising edge, `bus_rdata` shows the word at `bus_addr` after that edge. With no read, `bus_rdata` holds its value.
- R3: In word 0, bit 0 is the start policy (`op_start`) and bit 1 is the sensor enable (`sense_en`). Both are read/write. Bits 31:2 read zero.
- R4: In word 1, bit 0 is the dynamic adaptive enable, bits 20:1 are the compute delay and bits 26:21 are the step. All of these are read/write. Bits 31:27 read zero.
- R5: In word 2, bit 16 is the read/write device permission. The read-only fields are: live code (bits 15:10), default code (bits 9:4), policy permission (bit 3) and speed grade (bits 2:1). Bit 0 and bits 31:17 read zero. Writes do not change the read-only fields.
- R6: The speed-grade field reflects `grade_code` unchanged. The codes are 00 for grade -3, 11 for grade -2 and 10 for grade -1. Code 01 is reserved and is passed through as it is.
- R7: Word 3 is the read-only fuse image: valid in bit 30, grade -1 code in bits 29:24, grade -2 code in bits 21:16, grade -3 code in bits 13:8 and fuse adaptive permission in bit 4. All other bits read zero. Writes to word 3 have no effect.
- R8: Word 4 and the unmapped addresses 6 and 7 read zero. Writes to them change no register.
- R9: In word 5, bits 9:0 hold the temperature code and bit 16 holds the temperature-valid flag. Both read zero while `sense_en` is 0.
- R10: In word 5, bits 15:10 hold the adaptive code and read zero while `adapt_active_in` is 0. Bits 26:17 always show the temperature used, bit 27 shows the active flag, and bits 31:28 read zero.
- R11: `adapt_en` is high one cycle after `dyn_adapt_en`, `policy_adapt`, `dev_adapt_ok` and `fuse_adapt_ok` are all high. It falls one cycle after any one of them drops.
- R12: A write is stored at the rising edge where `bus_write` is high, and the control outputs change after that edge. Without a write, the control outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_read | input | 1 | Read strobe |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fuse_valid | input | 1 | Fuse image valid |
| fuse_adapt_ok | input | 1 | Fuse adaptive permission |
| fuse_vid_g1 | input | 6 | Fused code, grade -1 |
| fuse_vid_g2 | input | 6 | Fused code, grade -2 |
| fuse_vid_g3 | input | 6 | Fused code, grade -3 |
| grade_code | input | 2 | Speed-grade code |
| default_vid | input | 6 | Default voltage code |
| policy_adapt | input | 1 | Policy adaptive permission |
| live_vid | input | 6 | Code currently driven to the regulator |
| temp_code_in | input | 10 | Latest temperature code |
| temp_valid_in | input | 1 | Temperature code valid |
| adapt_vid_in | input | 6 | Last adaptive code |
| adapt_temp_in | input | 10 | Temperature used for that code |
| adapt_active_in | input | 1 | Adaptive logic active |
| op_start | output | 1 | Start policy |
| sense_en | output | 1 | Temperature sensor enable |
| dyn_adapt_en | output | 1 | Dynamic adaptive enable |
| comp_delay | output | 20 | Compute interval in microseconds |
| vid_step | output | 6 | Adjustment step count |
| dev_adapt_ok | output | 1 | Device adaptive permission |
| adapt_en | output | 1 | Combined adaptive enable |

## Verification
Several checks run on every cycle. Control outputs hold while no write is present, and a word-0 write lands after its edge. Read data holds between reads, and unmapped addresses read zero. The sensor and adaptive masks are checked in status reads, and the combined enable is checked to follow its four permissions with one cycle of lag. Other behaviour shows only in the bench scenarios: the exact bit placement of every field, that writes to read-only words and unmapped addresses do not disturb other registers, the pass-through of all four grade codes, and the reset values.

// File: rtl/vidreg_pkg.sv
`timescale 1ns/1ps
package vidreg_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int DELAY_W = 20;
  localparam int STEP_W  = 6;
  localparam int VID_W   = 6;
  localparam int TEMP_W  = 10;
  localparam int GRADE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL0  = 3'd0,
    RA_CTRL1  = 3'd1,
    RA_CTRL2  = 3'd2,
    RA_FUSELO = 3'd3,
    RA_FUSEHI = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  // word 0
  localparam int C0_START = 0;
  localparam int C0_SENSE = 1;
  // word 1
  localparam int C1_DYN      = 0;
  localparam int C1_DLY_LSB  = 1;
  localparam int C1_STEP_LSB = C1_DLY_LSB + DELAY_W;
  // word 2
  localparam int C2_GRADE_LSB = 1;
  localparam int C2_POLICY    = C2_GRADE_LSB + GRADE_W;
  localparam int C2_DEF_LSB   = C2_POLICY + 1;
  localparam int C2_LIVE_LSB  = C2_DEF_LSB + VID_W;
  localparam int C2_DEV       = C2_LIVE_LSB + VID_W;
  // word 3
  localparam int F_ADAPT  = 4;
  localparam int F_G3_LSB = 8;
  localparam int F_G2_LSB = 16;
  localparam int F_G1_LSB = 24;
  localparam int F_VALID  = 30;
  // word 5
  localparam int S_TEMP_LSB  = 0;
  localparam int S_VID_LSB   = S_TEMP_LSB + TEMP_W;
  localparam int S_TVALID    = S_VID_LSB + VID_W;
  localparam int S_UTEMP_LSB = S_TVALID + 1;
  localparam int S_ACTIVE    = S_UTEMP_LSB + TEMP_W;
endpackage

// File: rtl/vidreg_ctrl.sv
`timescale 1ns/1ps
module vidreg_ctrl
  import vidreg_pkg::*;
#(
  parameter int          DW        = DATA_W,
  parameter int          AW        = ADDR_W,
  parameter int          DLY_W     = DELAY_W,
  parameter int          STP_W     = STEP_W,
  parameter logic        START_RST = 1'b0,
  parameter logic        SENSE_RST = 1'b1,
  parameter int unsigned STEP_RST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             op_start,
  output logic             sense_en,
  output logic             dyn_en,
  output logic [DLY_W-1:0] delay,
  output logic [STP_W-1:0] step,
  output logic             dev_ok
);
  localparam int STP_LSB = C1_DLY_LSB + DLY_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_start <= START_RST;
      sense_en <= SENSE_RST;
      dyn_en   <= 1'b0;
      delay    <= '0;
      step     <= STP_W'(STEP_RST);
      dev_ok   <= 1'b0;
    end else if (wr) begin
      case (addr)
        RA_CTRL0: begin
          op_start <= wdata[C0_START];
          sense_en <= wdata[C0_SENSE];
        end
        RA_CTRL1: begin
          dyn_en <= wdata[C1_DYN];
          delay  <= wdata[C1_DLY_LSB +: DLY_W];
          step   <= wdata[STP_LSB +: STP_W];
        end
        RA_CTRL2: dev_ok <= wdata[C2_DEV];
        default: ;
      endcase
    end
  end

  a_r12_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable({op_start, sense_en, dyn_en, delay, step, dev_ok}));

  a_r12_word0_store: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == RA_CTRL0) |=> (op_start == $past(wdata[C0_START]) &&
                                  sense_en == $past(wdata[C0_SENSE])));
endmodule

// File: rtl/vidreg_rdmux.sv
`timescale 1ns/1ps
module vidreg_rdmux
  import vidreg_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int DLY_W = DELAY_W,
  parameter int STP_W = STEP_W,
  parameter int V_W   = VID_W,
  parameter int T_W   = TEMP_W,
  parameter int G_W   = GRADE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  output logic [DW-1:0]    rdata,
  input  logic             op_start,
  input  logic             sense_en,
  input  logic             dyn_en,
  input  logic [DLY_W-1:0] delay,
  input  logic [STP_W-1:0] step,
  input  logic             dev_ok,
  input  logic             fuse_valid,
  input  logic             fuse_adapt_ok,
  input  logic [V_W-1:0]   fuse_vid_g1,
  input  logic [V_W-1:0]   fuse_vid_g2,
  input  logic [V_W-1:0]   fuse_vid_g3,
  input  logic [G_W-1:0]   grade_code,
  input  logic [V_W-1:0]   default_vid,
  input  logic             policy_adapt,
  input  logic [V_W-1:0]   live_vid,
  input  logic [T_W-1:0]   temp_code_in,
  input  logic             temp_valid_in,
  input  logic [V_W-1:0]   adapt_vid_in,
  input  logic [T_W-1:0]   adapt_temp_in,
  input  logic             adapt_active_in
);
  localparam int STP_LSB = C1_DLY_LSB + DLY_W;

  logic [DW-1:0] w_ctrl0, w_ctrl1, w_ctrl2, w_fuse, w_stat, sel;

  always_comb begin
    w_ctrl0 = '0;
    w_ctrl0[C0_START] = op_start;
    w_ctrl0[C0_SENSE] = sense_en;

    w_ctrl1 = '0;
    w_ctrl1[C1_DYN] = dyn_en;
    w_ctrl1[C1_DLY_LSB +: DLY_W] = delay;
    w_ctrl1[STP_LSB +: STP_W] = step;

    w_ctrl2 = '0;
    w_ctrl2[C2_GRADE_LSB +: G_W] = grade_code;
    w_ctrl2[C2_POLICY] = policy_adapt;
    w_ctrl2[C2_DEF_LSB +: V_W] = default_vid;
    w_ctrl2[C2_LIVE_LSB +: V_W] = live_vid;
    w_ctrl2[C2_DEV] = dev_ok;

    w_fuse = '0;
    w_fuse[F_ADAPT] = fuse_adapt_ok;
    w_fuse[F_G3_LSB +: V_W] = fuse_vid_g3;
    w_fuse[F_G2_LSB +: V_W] = fuse_vid_g2;
    w_fuse[F_G1_LSB +: V_W] = fuse_vid_g1;
    w_fuse[F_VALID] = fuse_valid;

    w_stat = '0;
    w_stat[S_TEMP_LSB +: T_W] = sense_en ? temp_code_in : '0;
    w_stat[S_VID_LSB +: V_W] = adapt_active_in ? adapt_vid_in : '0;
    w_stat[S_TVALID] = sense_en & temp_valid_in;
    w_stat[S_UTEMP_LSB +: T_W] = adapt_temp_in;
    w_stat[S_ACTIVE] = adapt_active_in;
  end

  always_comb begin
    case (addr)
      RA_CTRL0:  sel = w_ctrl0;
      RA_CTRL1:  sel = w_ctrl1;
      RA_CTRL2:  sel = w_ctrl2;
      RA_FUSELO: sel = w_fuse;
      RA_STAT:   sel = w_stat;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

  a_r2_hold_no_read: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && (addr == RA_FUSEHI || addr > RA_STAT)) |=> rdata == '0);

  a_r9_sense_mask: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == RA_STAT && !sense_en) |=>
      (rdata[S_TEMP_LSB +: T_W] == '0 && !rdata[S_TVALID]));

  a_r10_vid_mask: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == RA_STAT && !adapt_active_in) |=> rdata[S_VID_LSB +: V_W] == '0);
endmodule

// File: rtl/vidreg_adapt.sv
`timescale 1ns/1ps
module vidreg_adapt #(
  parameter int N_TERMS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TERMS-1:0] terms,
  output logic               en
);
  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else     en <= &terms;
  end

  a_r11_rise: assert property (@(posedge clk) disable iff (rst)
    (&terms) |=> en);
  a_r11_fall: assert property (@(posedge clk) disable iff (rst)
    !(&terms) |=> !en);
endmodule

// File: rtl/vidreg_csr.sv
`timescale 1ns/1ps
module vidreg_csr
  import vidreg_pkg::*;
#(
  parameter logic        START_RST = 1'b0,
  parameter int unsigned STEP_RST  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_read,
  input  logic                bus_write,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                fuse_valid,
  input  logic                fuse_adapt_ok,
  input  logic [VID_W-1:0]    fuse_vid_g1,
  input  logic [VID_W-1:0]    fuse_vid_g2,
  input  logic [VID_W-1:0]    fuse_vid_g3,
  input  logic [GRADE_W-1:0]  grade_code,
  input  logic [VID_W-1:0]    default_vid,
  input  logic                policy_adapt,
  input  logic [VID_W-1:0]    live_vid,
  input  logic [TEMP_W-1:0]   temp_code_in,
  input  logic                temp_valid_in,
  input  logic [VID_W-1:0]    adapt_vid_in,
  input  logic [TEMP_W-1:0]   adapt_temp_in,
  input  logic                adapt_active_in,
  output logic                op_start,
  output logic                sense_en,
  output logic                dyn_adapt_en,
  output logic [DELAY_W-1:0]  comp_delay,
  output logic [STEP_W-1:0]   vid_step,
  output logic                dev_adapt_ok,
  output logic                adapt_en
);
  localparam int N_PERMIT = 4;

  vidreg_ctrl #(
    .DW(DATA_W), .AW(ADDR_W), .DLY_W(DELAY_W), .STP_W(STEP_W),
    .START_RST(START_RST), .SENSE_RST(1'b1), .STEP_RST(STEP_RST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_write), .addr(bus_addr), .wdata(bus_wdata),
    .op_start(op_start), .sense_en(sense_en), .dyn_en(dyn_adapt_en),
    .delay(comp_delay), .step(vid_step), .dev_ok(dev_adapt_ok)
  );

  vidreg_rdmux #(
    .DW(DATA_W), .AW(ADDR_W), .DLY_W(DELAY_W), .STP_W(STEP_W),
    .V_W(VID_W), .T_W(TEMP_W), .G_W(GRADE_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd(bus_read), .addr(bus_addr), .rdata(bus_rdata),
    .op_start(op_start), .sense_en(sense_en), .dyn_en(dyn_adapt_en),
    .delay(comp_delay), .step(vid_step), .dev_ok(dev_adapt_ok),
    .fuse_valid(fuse_valid), .fuse_adapt_ok(fuse_adapt_ok),
    .fuse_vid_g1(fuse_vid_g1), .fuse_vid_g2(fuse_vid_g2), .fuse_vid_g3(fuse_vid_g3),
    .grade_code(grade_code), .default_vid(default_vid), .policy_adapt(policy_adapt),
    .live_vid(live_vid), .temp_code_in(temp_code_in), .temp_valid_in(temp_valid_in),
    .adapt_vid_in(adapt_vid_in), .adapt_temp_in(adapt_temp_in),
    .adapt_active_in(adapt_active_in)
  );

  vidreg_adapt #(.N_TERMS(N_PERMIT)) u_adapt (
    .clk(clk), .rst(rst),
    .terms({dyn_adapt_en, policy_adapt, dev_adapt_ok, fuse_adapt_ok}),
    .en(adapt_en)
  );
endmodule

// File: tb/tb_vidreg_csr.sv
`timescale 1ns/1ps
module tb_vidreg_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_read = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fuse_valid = 0, fuse_adapt_ok = 0;
  logic [5:0]  fuse_vid_g1 = 0, fuse_vid_g2 = 0, fuse_vid_g3 = 0;
  logic [1:0]  grade_code = 0;
  logic [5:0]  default_vid = 0, live_vid = 0, adapt_vid_in = 0;
  logic        policy_adapt = 0, temp_valid_in = 0, adapt_active_in = 0;
  logic [9:0]  temp_code_in = 0, adapt_temp_in = 0;
  logic        op_start, sense_en, dyn_adapt_en, dev_adapt_ok, adapt_en;
  logic [19:0] comp_delay;
  logic [5:0]  vid_step;

  always #2.5 clk = ~clk;

  vidreg_csr dut (.*);

  int tests = 0, fails = 0;
  // model of read/write state, per requirements
  logic        m_start = 0, m_sense = 1, m_dyn = 0, m_dev = 0;
  logic [19:0] m_delay = 0;
  logic [5:0]  m_step = 2;
  logic [31:0] last_rd = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [2:0] a);
    case (a)
      3'd0: return {30'b0, m_sense, m_start};
      3'd1: return {5'b0, m_step, m_delay, m_dyn};
      3'd2: return {15'b0, m_dev, live_vid, default_vid, policy_adapt, grade_code, 1'b0};
      3'd3: return {1'b0, fuse_valid, fuse_vid_g1, 2'b0, fuse_vid_g2, 2'b0,
                    fuse_vid_g3, 3'b0, fuse_adapt_ok, 4'b0};
      3'd5: return {4'b0, adapt_active_in, adapt_temp_in, m_sense & temp_valid_in,
                    adapt_active_in ? adapt_vid_in : 6'd0, m_sense ? temp_code_in : 10'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1;
    case (a)
      3'd0: begin m_start = d[0]; m_sense = d[1]; end
      3'd1: begin m_dyn = d[0]; m_delay = d[20:1]; m_step = d[26:21]; end
      3'd2: m_dev = d[16];
      default: ;
    endcase
    @(negedge clk);
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_read = 1'b1;
    exp_q.push_back(exp_word(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_read = 1'b0;
  endtask

  // monitor: a read seen at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_read & ~rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2: actual %h expected no data", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_rd = e;
        chk(bus_rdata, e, t);
      end
    end
  end

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk(op_start, 0, "R1 op_start");
    chk(sense_en, 1, "R1 sense_en");
    chk(dyn_adapt_en, 0, "R1 dyn");
    chk(comp_delay, 0, "R1 delay");
    chk(vid_step, 2, "R1 step");
    chk(dev_adapt_ok, 0, "R1 dev");
    chk(adapt_en, 0, "R1 adapt_en");
    chk(bus_rdata, 0, "R1 rdata");
    bus_rd(3'd0, "R1 R3 word0 reset");
    bus_rd(3'd1, "R1 R4 word1 reset");

    // R12 write timing on word 0
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 32'hFFFF_FFFD; bus_write = 1'b1;
    m_start = 1; m_sense = 0;
    chk(op_start, 0, "R12 before edge");
    @(negedge clk);
    bus_write = 1'b0;
    chk(op_start, 1, "R12 after edge");
    chk(sense_en, 0, "R12 sense after edge");
    bus_rd(3'd0, "R3 reserved zero");

    // R4 word 1 fields
    bus_wr(3'd1, 32'hFFFF_FFFF);
    chk(comp_delay, 20'hFFFFF, "R4 delay all ones");
    chk(vid_step, 6'h3F, "R4 step all ones");
    chk(dyn_adapt_en, 1, "R4 dyn");
    bus_rd(3'd1, "R4 word1 ones");
    bus_wr(3'd1, (32'd5 << 21) | (32'd1234 << 1));
    chk(comp_delay, 20'd1234, "R4 delay pattern");
    bus_rd(3'd1, "R4 word1 pattern");

    // R5 word 2
    live_vid = 6'h2A; default_vid = 6'h15; policy_adapt = 1; grade_code = 2'b11;
    bus_wr(3'd2, 32'hFFFF_FFFF);
    chk(dev_adapt_ok, 1, "R5 dev set");
    bus_rd(3'd2, "R5 word2 ro fields");
    bus_wr(3'd2, 32'h0000_0000);
    bus_rd(3'd2, "R5 word2 ro untouched");

    // R6 grade codes
    for (int g = 0; g < 4; g++) begin
      grade_code = 2'(g);
      bus_rd(3'd2, "R6 grade code");
    end

    // R7 fuse image
    fuse_valid = 1; fuse_vid_g1 = 6'h3F; fuse_vid_g2 = 6'h21; fuse_vid_g3 = 6'h1C;
    fuse_adapt_ok = 1;
    bus_rd(3'd3, "R7 fuse layout");
    bus_wr(3'd3, 32'h0000_0000);
    bus_rd(3'd3, "R7 fuse write ignored");

    // R8 zero words and ignored writes
    bus_rd(3'd4, "R8 word4 zero");
    bus_rd(3'd6, "R8 addr6 zero");
    bus_rd(3'd7, "R8 addr7 zero");
    bus_wr(3'd4, 32'hFFFF_FFFF);
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_wr(3'd7, 32'hFFFF_FFFF);
    bus_rd(3'd0, "R8 word0 unchanged");
    bus_rd(3'd1, "R8 word1 unchanged");
    bus_rd(3'd2, "R8 word2 unchanged");
    bus_rd(3'd4, "R8 word4 still zero");

    // R9 / R10 status word
    temp_code_in = 10'h155; temp_valid_in = 1;
    adapt_vid_in = 6'h33; adapt_temp_in = 10'h244; adapt_active_in = 1;
    bus_rd(3'd5, "R9 sensor off masks temp");
    bus_wr(3'd0, 32'h3);
    bus_rd(3'd5, "R9 sensor on shows temp");
    adapt_active_in = 0;
    bus_rd(3'd5, "R10 inactive masks vid");

    // R2 hold without read
    live_vid = 6'h01;
    repeat (3) @(negedge clk);
    chk(bus_rdata, last_rd, "R2 hold without read");

    // R11 combined enable (policy, fuse, dev set; dyn currently 0)
    bus_wr(3'd2, 32'h0001_0000);
    chk(adapt_en, 0, "R11 dyn low");
    bus_wr(3'd1, 32'h1);
    chk(adapt_en, 0, "R11 one-cycle lag");
    @(negedge clk);
    chk(adapt_en, 1, "R11 all four high");
    policy_adapt = 0;
    @(negedge clk);
    chk(adapt_en, 0, "R11 policy drop");
    policy_adapt = 1;
    @(negedge clk);
    chk(adapt_en, 1, "R11 policy back");
    fuse_adapt_ok = 0;
    @(negedge clk);
    chk(adapt_en, 0, "R11 fuse drop");
    fuse_adapt_ok = 1;
    @(negedge clk);
    chk(adapt_en, 1, "R11 fuse back");
    bus_wr(3'd2, 32'h0);
    chk(adapt_en, 1, "R11 dev drop lag");
    @(negedge clk);
    chk(adapt_en, 0, "R11 dev drop");

    finish_run();
  end
endmodule